// File: doc/BRIEF.md
# RAM-Window FIFO Transfer Engine

This block is a bus master that lets peripherals treat regions of on-chip RAM as byte FIFOs. Each peripheral owns a requester index. A static map ties every requester to one of four pointer slots. Each slot describes one FIFO region through a base address and a size code. A peripheral raises a request carrying an operation code and, for writes, a data byte. The engine takes one request at a time. It takes the bus for one cycle, places the slot's RAM address on the bus, and moves the byte between the peripheral and RAM in that same cycle. It then advances the slot's pointers.

Writes that find the region full are refused. Reads that find it empty are refused. Both leave the pointers as they were, set a sticky error in the slot, and are reported back to the requester. An interrupt line combines the sticky errors of the slots whose interrupt enable is set. Apart from plain push and pop, a peripheral can clear its slot, or read ahead through a temporary pointer that it later commits or rewinds. While the engine holds the bus, the CPU and DMA grants are withheld.

Top module: `ram_fifo_engine`

## Requirements
- R1: Size code c (0..6; larger values act as 6) gives a region of 32<<c bytes. The RAM address is base + (pointer mod size). Requester i uses the slot named by map_set[2i+1:2i].
- R2: Successive accepted pushes write successive offsets and wrap to offset 0 after size bytes. Pops return the bytes in the order they were pushed.
- R3: A push (op 0) to a full region drives ram_we low, leaves all pointers unchanged, returns rsp_ovr=1 and sets the slot's sticky error.
- R4: A pop (op 1) or peek (op 2) that has no unread byte returns rsp_uflow=1 and rsp_rdata=0, leaves the pointers unchanged and sets the sticky error.
- R5: While ack is high, rsp_full and rsp_empty give the slot's state after the operation. Full means the occupancy from the read pointer equals size.
- R6: A peek (op 2) reads at the temporary pointer and advances only it. Commit (op 3) copies the temporary pointer into the read pointer. Rewind (op 4) copies the read pointer into the temporary pointer. A pop sets the temporary pointer to the new read pointer.
- R7: Clear (op 5) sets all three pointers of the slot to 0 and clears its sticky error.
- R8: Among requests raised together, the lowest requester index is served first. The others stay pending and are served later.
- R9: A request accepted at edge k gets the bus in the cycle after edge k. It gets a one-cycle ack on its own bit after edge k+1. No second request is accepted before that ack ends.
- R10: ram_en is high exactly in the engine's bus cycle, and cpu_gnt and dma_gnt are low then. At other times dma_gnt=dma_req and cpu_gnt=cpu_req&~dma_req.
- R11: irq is high when any slot with its set_irq_en bit set holds a sticky error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NREQ | Request level per requester, held until ack |
| req_op | input | 3*NREQ | Operation code per requester |
| req_wdata | input | 8*NREQ | Push byte per requester |
| map_set | input | 2*NREQ | Slot index per requester |
| set_base | input | ADDR_W*NSET | Region base per slot |
| set_size | input | 3*NSET | Size code per slot |
| set_irq_en | input | NSET | Interrupt enable per slot |
| ack | output | NREQ | One-cycle completion per requester |
| rsp_rdata | output | 8 | Byte read by pop or peek |
| rsp_full | output | 1 | Slot full after the operation |
| rsp_empty | output | 1 | Slot empty after the operation |
| rsp_ovr | output | 1 | Push refused because the slot was full |
| rsp_uflow | output | 1 | Read refused because nothing was unread |
| ram_en | output | 1 | Engine bus cycle active |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, same cycle |
| cpu_req | input | 1 | CPU bus request |
| cpu_gnt | output | 1 | CPU bus grant |
| dma_req | input | 1 | DMA bus request |
| dma_gnt | output | 1 | DMA bus grant |
| irq | output | 1 | Combined error interrupt |

## Verification
The smallest region (32 bytes) is filled byte by byte and then pushed once more. This separates the one push that reports full from the refused push after it. Draining the region shows whether the data order and the empty edge are right, and pushing again after the drain shows whether the write offset wraps. A 128-byte slot at another base checks the size decode against a different mask. Separately, two requesters raised together check the service order. A peek, rewind, commit and pop sequence on a 2048-byte slot tells the temporary pointer apart from the read pointer. Clears and an interrupt-disabled slot show that the sticky errors are wiped and that the enable gates the interrupt.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int SLOT_MAX_LOG = 11;
  localparam int CNT_W = SLOT_MAX_LOG + 1;
  localparam int MIN_BYTES = 32;
  localparam int MAX_CODE = 6;

  localparam logic [2:0] OP_PUSH   = 3'd0;
  localparam logic [2:0] OP_POP    = 3'd1;
  localparam logic [2:0] OP_PEEK   = 3'd2;
  localparam logic [2:0] OP_COMMIT = 3'd3;
  localparam logic [2:0] OP_REWIND = 3'd4;
  localparam logic [2:0] OP_CLEAR  = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} eng_st_e;
endpackage

// File: rtl/rfe_arb.sv
module rfe_arb #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   req,
  output logic [IDW-1:0] idx,
  output logic           any
);
  always_comb begin
    idx = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDW'(i);
    end
  end

  always_comb begin
    if (any) begin
      p_win_valid_r8: assert (req[idx]);
      p_win_lowest_r8: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
    end
  end
endmodule

// File: rtl/rfe_ptr_set.sv
module rfe_ptr_set
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] base,
  input  logic [2:0]        size_code,
  output logic [ADDR_W-1:0] addr,
  output logic              refuse_ovr,
  output logic              refuse_uf,
  output logic              full,
  output logic              empty,
  output logic              err
);
  logic [CNT_W-1:0] wp_q, rp_q, tp_q;
  logic [CNT_W-1:0] wp_d, rp_d, tp_d;
  logic             ovr_q, uf_q, ovr_d, uf_d;
  logic [2:0]       code;
  logic [CNT_W-1:0] size_v, mask, occ, ptr_sel;

  always_comb begin
    code   = (size_code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : size_code;
    size_v = CNT_W'(MIN_BYTES) << code;
    mask   = size_v - CNT_W'(1);
    occ    = wp_q - rp_q;
    full   = (occ == size_v);
    empty  = (occ == '0);
    case (op)
      OP_PUSH: ptr_sel = wp_q;
      OP_PEEK: ptr_sel = tp_q;
      default: ptr_sel = rp_q;
    endcase
    addr       = base + ADDR_W'(ptr_sel & mask);
    refuse_ovr = (op == OP_PUSH) && full;
    refuse_uf  = ((op == OP_POP) && empty) || ((op == OP_PEEK) && (tp_q == wp_q));
    err        = ovr_q | uf_q;
  end

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    tp_d  = tp_q;
    ovr_d = ovr_q | refuse_ovr;
    uf_d  = uf_q | refuse_uf;
    case (op)
      OP_PUSH: if (!full) wp_d = wp_q + CNT_W'(1);
      OP_POP: begin
        if (!empty) begin
          rp_d = rp_q + CNT_W'(1);
          tp_d = rp_q + CNT_W'(1);
        end
      end
      OP_PEEK:   if (tp_q != wp_q) tp_d = tp_q + CNT_W'(1);
      OP_COMMIT: rp_d = tp_q;
      OP_REWIND: tp_d = rp_q;
      OP_CLEAR: begin
        wp_d  = '0;
        rp_d  = '0;
        tp_d  = '0;
        ovr_d = 1'b0;
        uf_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      tp_q  <= '0;
      ovr_q <= 1'b0;
      uf_q  <= 1'b0;
    end else if (exec) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      tp_q  <= tp_d;
      ovr_q <= ovr_d;
      uf_q  <= uf_d;
    end
  end

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= size_v);
  p_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_PUSH && full |=> $stable(wp_q) && ovr_q);
  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_POP && empty |=> $stable(rp_q) && uf_q);
  p_tmp_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_q - rp_q) <= occ);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec && op == OP_CLEAR |=> empty && !err);
endmodule

// File: rtl/ram_fifo_engine.sv
module ram_fifo_engine
  import rfe_pkg::*;
#(
  parameter int NREQ   = 4,
  parameter int NSET   = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [3*NREQ-1:0]      req_op,
  input  logic [DATA_W*NREQ-1:0] req_wdata,
  input  logic [2*NREQ-1:0]      map_set,
  input  logic [ADDR_W*NSET-1:0] set_base,
  input  logic [3*NSET-1:0]      set_size,
  input  logic [NSET-1:0]        set_irq_en,
  output logic [NREQ-1:0]        ack,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   rsp_full,
  output logic                   rsp_empty,
  output logic                   rsp_ovr,
  output logic                   rsp_uflow,
  output logic                   ram_en,
  output logic                   ram_we,
  output logic [ADDR_W-1:0]      ram_addr,
  output logic [DATA_W-1:0]      ram_wdata,
  input  logic [DATA_W-1:0]      ram_rdata,
  input  logic                   cpu_req,
  output logic                   cpu_gnt,
  input  logic                   dma_req,
  output logic                   dma_gnt,
  output logic                   irq
);
  localparam int IDW  = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int SETW = 2;

  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [IDW-1:0] win_id;
  logic           win_any;

  rfe_arb #(.N(NREQ), .IDW(IDW)) u_arb (
    .req (req_valid),
    .idx (win_id),
    .any (win_any)
  );

  eng_st_e           st_q, st_d;
  logic [IDW-1:0]    id_q, id_d;
  logic [2:0]        op_q, op_d;
  logic [DATA_W-1:0] wd_q, wd_d, rd_q, rd_d;
  logic [SETW-1:0]   set_q, set_d;
  logic              ovr_q, ovr_d, uf_q, uf_d;

  logic [ADDR_W-1:0] s_addr [NSET];
  logic [NSET-1:0]   s_ovr, s_uf, s_full, s_empty, s_err;

  for (genvar s = 0; s < NSET; s++) begin : g_slot
    rfe_ptr_set #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_i_n),
      .exec       ((st_q == ST_BUSY) && (set_q == SETW'(s))),
      .op         (op_q),
      .base       (set_base[s*ADDR_W +: ADDR_W]),
      .size_code  (set_size[s*3 +: 3]),
      .addr       (s_addr[s]),
      .refuse_ovr (s_ovr[s]),
      .refuse_uf  (s_uf[s]),
      .full       (s_full[s]),
      .empty      (s_empty[s]),
      .err        (s_err[s])
    );
  end

  always_comb begin
    st_d  = st_q;
    id_d  = id_q;
    op_d  = op_q;
    wd_d  = wd_q;
    set_d = set_q;
    rd_d  = rd_q;
    ovr_d = ovr_q;
    uf_d  = uf_q;
    case (st_q)
      ST_IDLE: begin
        if (win_any) begin
          st_d  = ST_BUSY;
          id_d  = win_id;
          op_d  = req_op[int'(win_id)*3 +: 3];
          wd_d  = req_wdata[int'(win_id)*DATA_W +: DATA_W];
          set_d = map_set[int'(win_id)*SETW +: SETW];
        end
      end
      ST_BUSY: begin
        st_d  = ST_DONE;
        ovr_d = s_ovr[set_q];
        uf_d  = s_uf[set_q];
        rd_d  = ((op_q == OP_POP || op_q == OP_PEEK) && !s_uf[set_q]) ? ram_rdata : '0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q  <= ST_IDLE;
      id_q  <= '0;
      op_q  <= '0;
      wd_q  <= '0;
      set_q <= '0;
      rd_q  <= '0;
      ovr_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      id_q  <= id_d;
      op_q  <= op_d;
      wd_q  <= wd_d;
      set_q <= set_d;
      rd_q  <= rd_d;
      ovr_q <= ovr_d;
      uf_q  <= uf_d;
    end
  end

  always_comb begin
    ram_en    = (st_q == ST_BUSY);
    ram_addr  = ram_en ? s_addr[set_q] : '0;
    ram_we    = ram_en && (op_q == OP_PUSH) && !s_ovr[set_q];
    ram_wdata = ram_we ? wd_q : '0;
    dma_gnt   = dma_req && !ram_en;
    cpu_gnt   = cpu_req && !ram_en && !dma_req;
    irq       = |(s_err & set_irq_en);
    rsp_full  = s_full[set_q];
    rsp_empty = s_empty[set_q];
    rsp_rdata = rd_q;
    rsp_ovr   = ovr_q;
    rsp_uflow = uf_q;
    for (int i = 0; i < NREQ; i++) ack[i] = (st_q == ST_DONE) && (id_q == IDW'(i));
  end

  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(ack));
  p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|ack) |=> (ack == '0));
  p_ack_after_bus_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|ack) |-> $past(ram_en));
  p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    ram_en |-> !cpu_gnt && !dma_gnt);
  p_no_we_refused_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    ram_we |=> !rsp_ovr);
endmodule

// File: tb/sim_ram_fifo_engine.sv
module sim_ram_fifo_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req_valid;
  logic [11:0] req_op;
  logic [31:0] req_wdata;
  logic [7:0]  map_set;
  logic [47:0] set_base;
  logic [11:0] set_size;
  logic [3:0]  set_irq_en;
  logic [3:0]  ack;
  logic [7:0]  rsp_rdata, ram_wdata, ram_rdata;
  logic        rsp_full, rsp_empty, rsp_ovr, rsp_uflow;
  logic        ram_en, ram_we, cpu_req, cpu_gnt, dma_req, dma_gnt, irq;
  logic [11:0] ram_addr;
  logic [7:0]  mem [4096];

  int total = 0;
  int bad = 0;

  logic [7:0]  r_rd;
  logic        r_ovr, r_uf, r_full, r_empty, r_we, r_en;
  logic [11:0] r_addr;

  always #5 clk = ~clk;

  ram_fifo_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_wdata(req_wdata), .map_set(map_set), .set_base(set_base),
    .set_size(set_size), .set_irq_en(set_irq_en), .ack(ack),
    .rsp_rdata(rsp_rdata), .rsp_full(rsp_full), .rsp_empty(rsp_empty),
    .rsp_ovr(rsp_ovr), .rsp_uflow(rsp_uflow), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .irq(irq)
  );

  always @(posedge clk) if (ram_en && ram_we) mem[ram_addr] <= ram_wdata;
  assign ram_rdata = mem[ram_addr];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int id, input logic [2:0] op, input logic [7:0] wd);
    logic a1, g1;
    logic [3:0] a2;
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_op[id*3 +: 3] = op;
    req_wdata[id*8 +: 8] = wd;
    @(posedge clk); @(negedge clk);
    r_en = ram_en; r_we = ram_we; r_addr = ram_addr;
    g1 = cpu_gnt | dma_gnt;
    @(posedge clk); @(negedge clk);
    a2 = ack;
    r_rd = rsp_rdata; r_ovr = rsp_ovr; r_uf = rsp_uflow;
    r_full = rsp_full; r_empty = rsp_empty;
    req_valid[id] = 1'b0;
    @(posedge clk); @(negedge clk);
    a1 = |ack;
    chk("R10 bus cycle", {31'd0, r_en}, 32'd1);
    chk("R10 grants held low", {31'd0, g1}, 32'd0);
    chk("R9 ack bit", {28'd0, a2}, 32'd1 << id);
    chk("R9 ack single cycle", {31'd0, a1}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_wdata = '0;
    cpu_req = 1'b1; dma_req = 1'b0;
    map_set = {2'd3, 2'd2, 2'd1, 2'd0};
    set_base = {12'h800, 12'h400, 12'h200, 12'h100};
    set_size = {3'd6, 3'd2, 3'd1, 3'd0};
    set_irq_en = 4'b0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset ack", {28'd0, ack}, 32'd0);
    chk("R10 reset ram_en", {31'd0, ram_en}, 32'd0);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    chk("R10 reset cpu grant", {31'd0, cpu_gnt}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_fill_wrap;
    for (int i = 0; i < 32; i++) begin
      issue(0, 3'd0, 8'hA0 + 8'(i));
      chk("R1 push address", {20'd0, r_addr}, 32'h100 + i);
      chk("R2 push strobe", {31'd0, r_we}, 32'd1);
      chk("R5 full flag", {31'd0, r_full}, (i == 31) ? 32'd1 : 32'd0);
    end
    chk("R11 irq before error", {31'd0, irq}, 32'd0);
    issue(0, 3'd0, 8'h55);
    chk("R3 overrun", {31'd0, r_ovr}, 32'd1);
    chk("R3 no write", {31'd0, r_we}, 32'd0);
    chk("R11 irq on overrun", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 32; i++) begin
      issue(0, 3'd1, 8'h00);
      chk("R2 pop data", {24'd0, r_rd}, 32'hA0 + i);
      chk("R2 pop address", {20'd0, r_addr}, 32'h100 + i);
      chk("R5 empty flag", {31'd0, r_empty}, (i == 31) ? 32'd1 : 32'd0);
    end
    issue(0, 3'd1, 8'h00);
    chk("R4 underflow", {31'd0, r_uf}, 32'd1);
    chk("R4 zero data", {24'd0, r_rd}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      issue(0, 3'd0, 8'hC0 + 8'(i));
      chk("R2 wrap address", {20'd0, r_addr}, 32'h100 + i);
    end
  endtask

  task automatic t_clear;
    issue(0, 3'd5, 8'h00);
    chk("R7 empty after clear", {31'd0, r_empty}, 32'd1);
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);
    issue(0, 3'd0, 8'h77);
    chk("R7 pointer zeroed", {20'd0, r_addr}, 32'h100);
  endtask

  task automatic t_arb;
    logic [3:0] a;
    @(negedge clk);
    req_valid[1] = 1'b1; req_op[5:3] = 3'd0; req_wdata[15:8] = 8'h11;
    req_valid[2] = 1'b1; req_op[8:6] = 3'd0; req_wdata[23:16] = 8'h22;
    @(posedge clk); @(negedge clk);
    chk("R8 first winner slot", {20'd0, ram_addr}, 32'h200);
    @(posedge clk); @(negedge clk);
    chk("R8 first ack", {28'd0, ack}, 32'h2);
    req_valid[1] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 gap before next", {31'd0, ram_en}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 second winner slot", {20'd0, ram_addr}, 32'h400);
    @(posedge clk); @(negedge clk);
    a = ack;
    req_valid[2] = 1'b0;
    chk("R8 second ack", {28'd0, a}, 32'h4);
    @(posedge clk);
  endtask

  task automatic t_peek;
    dma_req = 1'b1;
    issue(3, 3'd0, 8'h11);
    chk("R1 large slot base", {20'd0, r_addr}, 32'h800);
    issue(3, 3'd0, 8'h22);
    issue(3, 3'd0, 8'h33);
    issue(3, 3'd2, 8'h00);
    chk("R6 peek 1", {24'd0, r_rd}, 32'h11);
    issue(3, 3'd2, 8'h00);
    chk("R6 peek 2", {24'd0, r_rd}, 32'h22);
    chk("R6 peek address", {20'd0, r_addr}, 32'h801);
    issue(3, 3'd4, 8'h00);
    issue(3, 3'd2, 8'h00);
    chk("R6 rewind", {24'd0, r_rd}, 32'h11);
    issue(3, 3'd3, 8'h00);
    chk("R6 commit not empty", {31'd0, r_empty}, 32'd0);
    issue(3, 3'd1, 8'h00);
    chk("R6 pop after commit", {24'd0, r_rd}, 32'h22);
    issue(3, 3'd2, 8'h00);
    chk("R6 peek after pop", {24'd0, r_rd}, 32'h33);
    issue(3, 3'd2, 8'h00);
    chk("R4 peek underflow", {31'd0, r_uf}, 32'd1);
    issue(3, 3'd1, 8'h00);
    chk("R6 pop keeps order", {24'd0, r_rd}, 32'h33);
    chk("R11 disabled slot irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 dma over cpu", {30'd0, dma_gnt, cpu_gnt}, 32'h2);
    dma_req = 1'b0;
    @(negedge clk);
    chk("R10 cpu when dma idle", {30'd0, dma_gnt, cpu_gnt}, 32'h1);
  endtask

  task automatic t_size;
    issue(2, 3'd5, 8'h00);
    for (int i = 0; i < 128; i++) begin
      issue(2, 3'd0, 8'(i));
      if (i == 0) chk("R1 128-byte base", {20'd0, r_addr}, 32'h400);
      if (i >= 126) chk("R5 full at 128", {31'd0, r_full}, (i == 127) ? 32'd1 : 32'd0);
    end
    issue(2, 3'd0, 8'hFF);
    chk("R3 overrun at 128", {31'd0, r_ovr}, 32'd1);
    chk("R11 irq gated by enable", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_wrap();
    t_clear();
    t_arb();
    t_peek();
    t_size();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule